// File: doc/BRIEF.md
# Sequential Radix-4 Signed Multiplier

This block multiplies two signed two's-complement operands of width W over several clock cycles. A single narrow adder and one accumulator register are used again on every step. The multiplier operand is read two bits at a time, and each pair is recoded into a digit from the set {-2,-1,0,+1,+2}. Every step therefore adds zero, the multiplicand, or twice the multiplicand, each possibly negated. A multiply needs W/2 steps, and no threefold multiple is ever formed.

The accumulator keeps the running sum in its upper part, which is W+2 bits wide. The lower W bits start out holding the multiplier. After each addition the whole accumulator shifts right arithmetically by two positions. The sum bits that drop out of the adder window fill the space left by the multiplier bits already consumed. A caller pulses `start` with both operands. The 2W-bit product appears together with a one-cycle `done` pulse and stays on the output until the next accepted start.

Top module: `r4_seq_mult`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `product` is 0 until the first accepted start.
- R2: `product` equals the signed product of the accepted `mcand` and `mplier`, as a 2W-bit two's-complement value.
- R3: `done` is high for exactly one cycle. It rises on the W/2-th rising edge after the edge that accepted `start`. `busy` is high from the accepting edge until that same edge.
- R4: A `start` seen while `busy` is high is ignored. The multiply in progress keeps its operands, and no extra `done` is produced.
- R5: The extreme operands give correct products: the most negative value times itself, the most negative value times the most positive value, and the most positive value squared.
- R6: A `start` given in the same cycle that `done` is high is accepted. Its result is correct and arrives on time.
- R7: While idle, `product` holds its last value whatever the operand inputs do, until a new start is accepted.
- R8: Each step recodes the triplet (bit 2i+1, bit 2i, bit 2i-1) of the multiplier, with a 0 below bit 0, as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. A negative digit adds the inverted multiple with a carry-in of 1. Multiplier patterns that produce every triplet value give correct products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; taken only when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: product is ready |
| product | output | 2W | Signed 2W-bit result |

## Verification
A result hand-off and a new request can share one cycle: the cycle where `done` is high is also the first idle cycle, so a `start` there must be accepted while the old product is still being read. The bench provokes this by issuing queued multiplies back to back. Its driver waits only for `busy` to drop, so its next start lands exactly on the `done` cycle. The monitor compares the product seen in that cycle with the older expected value, and then checks that the next result has the right value and arrives on the predicted cycle.

// File: rtl/r4m_pkg.sv
package r4m_pkg;
   // one recoded radix-4 digit: sign, magnitude two, magnitude one
   typedef struct packed {
      logic neg;
      logic dbl;
      logic sgl;
   } r4m_digit_t;

   localparam int unsigned R4M_BITS_PER_STEP = 2;
endpackage

// File: rtl/r4m_recoder.sv
module r4m_recoder
   import r4m_pkg::*;
(
   input  logic [2:0]  trip,
   output r4m_digit_t  dig
);
   always_comb begin
      dig = '0;
      unique case (trip)
         3'b001, 3'b010: dig = '{neg: 1'b0, dbl: 1'b0, sgl: 1'b1};
         3'b011:         dig = '{neg: 1'b0, dbl: 1'b1, sgl: 1'b0};
         3'b100:         dig = '{neg: 1'b1, dbl: 1'b1, sgl: 1'b0};
         3'b101, 3'b110: dig = '{neg: 1'b1, dbl: 1'b0, sgl: 1'b1};
         default:        dig = '0;
      endcase
   end
endmodule

// File: rtl/r4m_multiple.sv
module r4m_multiple
   import r4m_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] mcand,
   input  r4m_digit_t   dig,
   output logic [W+1:0] addend,
   output logic         cin
);
   localparam int unsigned HW = W + 2;

   logic [HW-1:0] ext;
   assign ext = {{2{mcand[W-1]}}, mcand};

   // per-bit select of x1 / x2 / 0, then conditional inversion
   for (genvar i = 0; i < HW; i++) begin : g_bit
      logic lo_src;
      if (i == 0) begin : g_lsb
         assign lo_src = 1'b0;
      end else begin : g_upper
         assign lo_src = ext[i-1];
      end
      assign addend[i] = ((dig.sgl & ext[i]) | (dig.dbl & lo_src)) ^ dig.neg;
   end

   assign cin = dig.neg;
endmodule

// File: rtl/r4m_seq_ctrl.sv
module r4m_seq_ctrl #(
   parameter int unsigned STEPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic load,
   output logic step
);
   localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   logic [CW-1:0] cnt_q;
   logic          last;

   assign load = start & ~busy;
   assign step = busy;
   assign last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt_q <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy  <= 1'b1;
            cnt_q <= '0;
         end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R3
   count_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/r4_seq_mult.sv
module r4_seq_mult
   import r4m_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   mcand,
   input  logic [W-1:0]   mplier,
   output logic           busy,
   output logic           done,
   output logic [2*W-1:0] product
);
   localparam int unsigned HW    = W + 2;
   localparam int unsigned STEPS = W / R4M_BITS_PER_STEP;

   if ((W % 2) != 0 || W < 4) begin : g_bad_width
      $error("r4_seq_mult: W must be even and at least 4");
   end

   logic          load, step;
   logic [HW-1:0] hi_q;
   logic [W-1:0]  lo_q;
   logic          qm1_q;
   logic [W-1:0]  mcand_q;
   r4m_digit_t    dig;
   logic [HW-1:0] addend;
   logic          cin;
   logic [HW-1:0] sum;

   r4m_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done),
      .load  (load),
      .step  (step)
   );

   r4m_recoder u_rec (
      .trip ({lo_q[1:0], qm1_q}),
      .dig  (dig)
   );

   r4m_multiple #(.W(W)) u_mult (
      .mcand  (mcand_q),
      .dig    (dig),
      .addend (addend),
      .cin    (cin)
   );

   assign sum = hi_q + addend + {{(HW-1){1'b0}}, cin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo_q    <= '0;
         qm1_q   <= 1'b0;
         mcand_q <= '0;
      end else if (load) begin
         hi_q    <= '0;
         lo_q    <= mplier;
         qm1_q   <= 1'b0;
         mcand_q <= mcand;
      end else if (step) begin
         hi_q    <= {{2{sum[HW-1]}}, sum[HW-1:2]};
         lo_q    <= {sum[1:0], lo_q[W-1:2]};
         qm1_q   <= lo_q[1];
      end
   end

   assign product = {hi_q[W-1:0], lo_q};

   // R4
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(mcand_q));

   // R7
   product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));
endmodule

// File: tb/r4_seq_mult_tb_top.sv
module r4_seq_mult_tb_top;
   localparam int W     = 16;
   localparam int STEPS = W / 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   mcand = '0;
   logic [W-1:0]   mplier = '0;
   logic           busy, done;
   logic [2*W-1:0] product;

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   bit prev_done = 1'b0;
   logic [2*W-1:0] last_exp = '0;

   logic [2*W-1:0] exp_q[$];
   int             due_q[$];
   string          tag_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   r4_seq_mult #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
      .mplier(mplier), .busy(busy), .done(done), .product(product)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each done pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected done", 64'(product), 64'd0);
            end else begin
               logic [2*W-1:0] e;
               int d;
               string t;
               e = exp_q.pop_front();
               d = due_q.pop_front();
               t = tag_q.pop_front();
               chk(product == e, {t, " product"}, 64'(product), 64'(e));
               chk(cyc == d, {t, " R3 done timing"}, 64'(cyc), 64'(d));
               last_exp = e;
            end
         end
         if (prev_done && done) chk(1'b0, "R3 done width", 64'd2, 64'd1);
         prev_done = done;
      end
   end

   // driver: waits for idle, issues one start, pushes the expectation
   task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                      input string tag);
      logic signed [2*W-1:0] e;
      @(negedge clk);
      while (busy) @(negedge clk);
      mcand  = a;
      mplier = b;
      start  = 1'b1;
      e = $signed(a) * $signed(b);
      exp_q.push_back(e);
      due_q.push_back(cyc + 1 + STEPS);
      tag_q.push_back(tag);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy || exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(!busy && !done, "R1 flags in reset", {busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !done && product == 0, "R1 after reset", 64'(product), 0);

      // R2 ordinary operands
      run(16'd3, 16'd5, "R2");
      run(-16'sd3, 16'd5, "R2");
      run(16'd1234, -16'sd77, "R2");
      run(16'd1, -16'sd1, "R2");
      run(16'd0, 16'h8000, "R2");
      wait_idle();

      // R5 extremes
      run(16'h8000, 16'h8000, "R5");
      run(16'h8000, 16'h7FFF, "R5");
      run(16'h7FFF, 16'h7FFF, "R5");
      wait_idle();

      // R8 every triplet: alternating, paired and all-ones patterns
      run(16'h1234, 16'h5555, "R8");
      run(16'h7ABC, 16'hAAAA, "R8");
      run(16'hF00D, 16'h3333, "R8");
      run(16'h0FED, 16'hCCCC, "R8");
      run(16'h4321, 16'hFFFF, "R8");
      run(16'h8001, 16'h9E37, "R8");
      wait_idle();

      // R4 start while busy is ignored
      run(16'd250, -16'sd40, "R4");
      mcand = 16'h7777; mplier = 16'h1111; start = 1'b1;
      @(negedge clk);
      chk(busy, "R4 still busy", 64'(busy), 1);
      @(negedge clk);
      start = 1'b0;
      wait_idle();

      // R7 hold while idle with changing inputs
      mcand = 16'h0F0F; mplier = 16'hF0F0;
      repeat (3) @(negedge clk);
      mcand = 16'h1357;
      repeat (2) @(negedge clk);
      chk(product == last_exp, "R7 hold", 64'(product), 64'(last_exp));

      // R6 back-to-back: each start lands on the previous done cycle
      run(16'd7, 16'd9, "R6");
      run(-16'sd100, -16'sd200, "R6");
      run(16'h7FFF, 16'h8000, "R6");
      wait_idle();

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule